// File: doc/BRIEF.md
# Sequential Significand Multiplier with Sticky Reduction

This unit multiplies two normalized single-precision significands (24 bits each, leading one present) and returns a 27-bit rounding-ready product. The product has 24 significant bits followed by guard, round and sticky bits. A separate flag tells the exponent path to add one when the raw product reached the upper binade.

Each significand is first placed at the top of a 32-bit word. The unit has a single 16x16 multiplier. On each of four consecutive cycles it forms one partial product and adds it into a wide accumulator at the right offset. Only the upper 32-bit word of the full 64-bit product is kept. Every bit below that word folds into its least significant bit as sticky information. The kept word is then shifted right by 4 or 5 places, and every bit that leaves also folds into the sticky position.

A request is issued with a one-cycle `start_i` while the unit is idle. The result appears with a one-cycle `done_o` pulse. Exponent sums, signs and the later alignment and addition belong to the surrounding datapath.

Top module: `mant_mul_sticky`

## Requirements
- R1: While reset is held, and after it is released with no request, `busy_o`, `done_o`, `exp_inc_o` and `prod_o` are all zero.
- R2: A high `start_i` sampled at a rising edge while `busy_o` is low starts an operation. `busy_o` is then high for exactly four cycles. `done_o` is high for exactly one cycle, the one that follows the fourth rising edge after acceptance, and `busy_o` is low in that cycle.
- R3: When `done_o` is high, `prod_o` equals the reduction of the exact product P = A*B. The kept word K is bits 47..16 of P, with bit 0 of K ORed with (P[15:0] != 0).
- R4: If bit 31 of K is set, `prod_o` is K[31:5] with bit 0 ORed with (K[4:0] != 0), and `exp_inc_o` is 1.
- R5: If bit 31 of K is clear, `prod_o` is K[30:4] with bit 0 ORed with (K[3:0] != 0), and `exp_inc_o` is 0.
- R6: Bit 26 of `prod_o` is set whenever `done_o` is high.
- R7: Bit 0 of `prod_o` is the OR of the kept-word bit at the shift boundary and every bit shifted out below it, including all of P[15:0]. A product whose discarded bits are all zero yields bit 0 equal to the plain truncated bit.
- R8: A `start_i` asserted while `busy_o` is high is ignored. The running operation keeps its operands and its timing, and `prod_o` reports the original operands' product.
- R9: `prod_o` and `exp_inc_o` hold their values from the `done_o` cycle until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted only while idle |
| mant_a_i | input | 24 | First significand, bit 23 set |
| mant_b_i | input | 24 | Second significand, bit 23 set |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| prod_o | output | 27 | 24 significant bits plus guard, round, sticky |
| exp_inc_o | output | 1 | Product fell in the upper binade; exponent needs +1 |

## Verification
Three kinds of internal fault show up differently at the ports.

- A wrong partial-product select or offset corrupts `prod_o` in the `done_o` cycle of the same request. It usually also flips `exp_inc_o` or clears bit 26.
- A lost sticky contribution only shows at bit 0, and only for operand pairs whose low product bits are non-zero. Directed pairs with a single low set bit therefore sit next to the random ones.
- A phase-counter or busy-state error moves the `done_o` pulse off the fourth edge, or lets a mid-operation `start_i` reload operands. Either is visible within five cycles of acceptance.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  // partial-product order: low x low first, high x high last
  typedef enum logic [1:0] {
    PP_LL = 2'd0,
    PP_LH = 2'd1,
    PP_HL = 2'd2,
    PP_HH = 2'd3
  } pp_sel_e;
endpackage

// File: rtl/mmul_ctrl.sv
module mmul_ctrl
  import mmul_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  output logic    load_o,
  output logic    acc_en_o,
  output pp_sel_e sel_o,
  output logic    busy_o,
  output logic    done_o
);
  logic    busy_q;
  logic    done_q;
  pp_sel_e sel_q;

  assign load_o   = start_i & ~busy_q;
  assign acc_en_o = busy_q;
  assign sel_o    = sel_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= PP_LL;
    end else begin
      done_q <= busy_q && (sel_q == PP_HH);
      if (load_o) begin
        busy_q <= 1'b1;
        sel_q  <= PP_LL;
      end else if (busy_q) begin
        if (sel_q == PP_HH) busy_q <= 1'b0;
        sel_q <= pp_sel_e'(sel_q + 2'd1);
      end
    end
  end

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r8_phase_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sel_q != PP_HH) |=> (busy_o && sel_q == pp_sel_e'($past(sel_q) + 2'd1)));
endmodule

// File: rtl/mmul_pp.sv
module mmul_pp
  import mmul_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W
) (
  input  logic [WORD_W-1:0] opa_i,
  input  logic [WORD_W-1:0] opb_i,
  input  pp_sel_e           sel_i,
  output logic [ACC_W-1:0]  term_o
);
  logic [HALF_W-1:0] x, y;
  logic [WORD_W-1:0] prod;
  logic [ACC_W-1:0]  ext;

  always_comb begin
    unique case (sel_i)
      PP_LL: begin x = opa_i[HALF_W-1:0];      y = opb_i[HALF_W-1:0];      end
      PP_LH: begin x = opa_i[HALF_W-1:0];      y = opb_i[WORD_W-1:HALF_W]; end
      PP_HL: begin x = opa_i[WORD_W-1:HALF_W]; y = opb_i[HALF_W-1:0];      end
      default: begin x = opa_i[WORD_W-1:HALF_W]; y = opb_i[WORD_W-1:HALF_W]; end
    endcase
  end

  // the one shared multiplier
  assign prod = x * y;
  assign ext  = {{WORD_W{1'b0}}, prod};

  always_comb begin
    unique case (sel_i)
      PP_LL:   term_o = ext;
      PP_LH,
      PP_HL:   term_o = ext << HALF_W;
      default: term_o = ext << WORD_W;
    endcase
  end
endmodule

// File: rtl/mmul_norm.sv
module mmul_norm #(
  parameter int HALF_W = 16,
  parameter int RES_W  = 27,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W,
  localparam int SH_LO  = WORD_W - RES_W - 1,
  localparam int SH_HI  = WORD_W - RES_W
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [RES_W-1:0] res_o,
  output logic             inc_o
);
  logic [WORD_W-1:0] kept;

  assign kept  = acc_i[ACC_W-1:WORD_W] | {{(WORD_W-1){1'b0}}, |acc_i[WORD_W-1:0]};
  assign inc_o = kept[WORD_W-1];

  always_comb begin
    if (kept[WORD_W-1]) begin
      res_o    = kept[WORD_W-1 -: RES_W];
      res_o[0] = res_o[0] | (|kept[SH_HI-1:0]);
    end else begin
      res_o    = kept[WORD_W-2 -: RES_W];
      res_o[0] = res_o[0] | (|kept[SH_LO-1:0]);
    end
  end
endmodule

// File: rtl/mant_mul_sticky.sv
module mant_mul_sticky
  import mmul_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int HALF_W = 16,
  parameter int GRS_W  = 3,
  localparam int WORD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W,
  localparam int PAD_W  = WORD_W - MANT_W,
  localparam int RES_W  = MANT_W + GRS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MANT_W-1:0] mant_a_i,
  input  logic [MANT_W-1:0] mant_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  prod_o,
  output logic              exp_inc_o
);
  logic              load, acc_en;
  pp_sel_e           sel;
  logic [WORD_W-1:0] opa_q, opb_q;
  logic [ACC_W-1:0]  acc_q, term;

  mmul_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_o(load), .acc_en_o(acc_en), .sel_o(sel),
    .busy_o(busy_o), .done_o(done_o)
  );

  mmul_pp #(.HALF_W(HALF_W)) u_pp (
    .opa_i(opa_q), .opb_i(opb_q), .sel_i(sel), .term_o(term)
  );

  mmul_norm #(.HALF_W(HALF_W), .RES_W(RES_W)) u_norm (
    .acc_i(acc_q), .res_o(prod_o), .inc_o(exp_inc_o)
  );

  // left-justify operands in the word; clear accumulator on load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q <= '0;
      opb_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      opa_q <= {mant_a_i, {PAD_W{1'b0}}};
      opb_q <= {mant_b_i, {PAD_W{1'b0}}};
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_q + term;
    end
  end

  a_r6_hidden_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> prod_o[RES_W-1]);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(start_i)) |-> ($stable(prod_o) && $stable(exp_inc_o)));
  a_r2_no_done_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

// File: tb/sim_mant_mul_sticky.sv
`timescale 1ns/1ps
module sim_mant_mul_sticky;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] ma = '0, mb = '0;
  logic        busy, done, inc;
  logic [26:0] prod;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mant_mul_sticky u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mant_a_i(ma), .mant_b_i(mb),
    .busy_o(busy), .done_o(done), .prod_o(prod), .exp_inc_o(inc)
  );

  function automatic logic [27:0] ref_fn(input logic [23:0] a, input logic [23:0] b);
    logic [47:0] p;
    logic [31:0] k;
    logic [26:0] r;
    logic        f;
    p = 48'(a) * 48'(b);
    k = p[47:16];
    k[0] = k[0] | (p[15:0] != 0);
    if (k[31]) begin
      r = k[31:5]; r[0] = r[0] | (k[4:0] != 0); f = 1'b1;
    end else begin
      r = k[30:4]; r[0] = r[0] | (k[3:0] != 0); f = 1'b0;
    end
    return {f, r};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [23:0] a, input logic [23:0] b, input bit poke);
    logic [27:0] e;
    logic [26:0] held;
    e = ref_fn(a, b);
    @(negedge clk);
    ma = a; mb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    for (int i = 0; i < 3; i++) begin
      if (poke && i == 1) begin
        ma = ~a | 24'h800000; mb = 24'h800000; start = 1'b1; // R8
      end
      @(negedge clk);
      start = 1'b0;
      check(done === 1'b0 && busy === 1'b1, "R2 early done", {done, busy}, 64'b01);
    end
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R2 done timing", {done, busy}, 64'b10);
    check(prod === e[26:0], poke ? "R8 value" : "R3 value", 64'(prod), 64'(e[26:0]));
    check(inc === e[27], e[27] ? "R4 increment" : "R5 no increment", 64'(inc), 64'(e[27]));
    check(prod[26] === 1'b1, "R6 hidden bit", 64'(prod[26]), 64'd1);
    check(prod[0] === e[0], "R7 sticky", 64'(prod[0]), 64'(e[0]));
    held = prod;
    @(negedge clk);
    check(done === 1'b0, "R2 single pulse", 64'(done), 64'd0);
    @(negedge clk);
    check(prod === held && inc === e[27], "R9 hold", 64'(prod), 64'(held));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    #1;
    check(busy === 0 && done === 0 && inc === 0 && prod === 0, "R1 in reset",
          {busy, done, inc, prod}, 64'd0);
    #9 rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(busy === 0 && done === 0 && inc === 0 && prod === 0, "R1 after reset",
          {busy, done, inc, prod}, 64'd0);
    // directed corners
    run_op(24'h800000, 24'h800000, 1'b0); // R5 exact, no sticky
    run_op(24'hffffff, 24'hffffff, 1'b0); // R4 upper binade
    run_op(24'h800001, 24'h800001, 1'b0); // R7 low bits only
    run_op(24'hb504f3, 24'hb504f3, 1'b0); // near binade boundary
    run_op(24'hc00000, 24'hab0001, 1'b1); // R8 start while busy
    for (int n = 0; n < 300; n++) begin
      logic [23:0] a, b;
      a = {1'b1, 23'($urandom)};
      b = {1'b1, 23'($urandom)};
      run_op(a, b, (n % 17) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule